// File: doc/BRIEF.md
# Dual-Path Run Command Agreement Monitor

This block watches one run command that arrives by two independent routes: a discrete level wire and a flag carried on a serial link. The serial flag is delivered as a value with a one-cycle valid strobe. The block keeps the last delivered value. When only one route says "run", the block opens a timing window counted in external ticks. If the other route does not confirm before the window closes, the block latches a relay fault and holds the validated run output low until reset. If both routes confirm, the validated run output follows their agreement. If both withdraw inside the window, the window is cancelled without a fault.

Two variants are selected by a parameter. In the symmetric variant, whichever route asserts first opens the window; this suits a long window, for example 50 ticks of 0.1 s. In the wire-led variant, only the discrete wire opens the window and the serial flag must follow it; this suits a short window, for example a single tick. The window length is a parameter. Serial decoding and relay driving belong to neighbouring blocks.

Top module: `dual_run_monitor`

## Requirements
- R1: During and after reset, runValid and runFault are 0. After reset the block does not open a window until both routes have been seen deasserted at the same time. Until then, any number of ticks raises no fault.
- R2: With ARM_WIRE_ONLY=0, a lone assertion on either route opens the window.
- R3: runValid is 1 only in cycles where both routes are asserted. It first rises in the cycle after the first cycle in which both are seen asserted together.
- R4: runFault rises in the cycle after the WINDOW_TICKS-th tick counted inside an open window, unless agreement or cancellation happens first. The tick in the cycle that opens the window is not counted.
- R5: Once runFault is 1, it stays 1 and runValid stays 0 until rstN is asserted (active low), whatever the inputs do.
- R6: If both routes are deasserted while the window is open, the window closes with no fault. A later window counts from zero.
- R7: If agreement is reached in the same cycle as the expiring tick, agreement wins: runValid goes to 1 and no fault is raised.
- R8: With ARM_WIRE_ONLY=1, a lone serial assertion opens no window and never causes a fault. Only the wire opens the window.
- R9: The serial route's level is linkRun in a cycle where linkValid is 1. Otherwise it is the value from the most recent strobe, or 0 if there has been no strobe since reset.
- R10: While running, if one route withdraws and the other stays asserted, a fresh window opens and counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; the only way to clear a fault |
| tick | input | 1 | One-cycle pulse that advances the window count |
| wireRun | input | 1 | Discrete run level (already synchronised) |
| linkValid | input | 1 | Strobe: linkRun carries a new serial run value |
| linkRun | input | 1 | Serial run value, sampled when linkValid is 1 |
| runValid | output | 1 | Run command confirmed by both routes |
| runFault | output | 1 | Latched run-relay fault |

## Verification
The sharpest overlap is the expiring window tick arriving in the same cycle as the serial strobe that completes agreement. The bench provokes this by driving the strobe together with the final tick, and it expects run rather than a fault. A behavioural model compares both outputs of two instances every cycle: a six-tick symmetric instance and a three-tick wire-led instance. In the same stimulus the short instance trips while the long one recovers. Directed checks also cover the reset block, window cancellation, and a lone serial assertion that one variant ignores and the other faults on.

// File: rtl/run_mon_pkg.sv
package run_mon_pkg;
  typedef enum logic [2:0] {
    ST_BLOCK,
    ST_IDLE,
    ST_WINDOW,
    ST_RUN,
    ST_FAULT
  } monState_t;

  typedef struct packed {
    logic winClear;
    logic winCount;
  } winCtrl_t;
endpackage

// File: rtl/run_mon_dp.sv
module run_mon_dp
  import run_mon_pkg::*;
#(
  parameter int WINDOW_TICKS = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     wireRun,
  input  logic     linkValid,
  input  logic     linkRun,
  input  winCtrl_t ctrl,
  output logic     wireNow,
  output logic     linkNow,
  output logic     expire
);
  localparam int CNT_W = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

  logic             linkHeld;
  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkHeld <= 1'b0;
    else if (linkValid) linkHeld <= linkRun;
  end

  assign wireNow = wireRun;
  assign linkNow = linkValid ? linkRun : linkHeld;
  assign expire  = ctrl.winCount && tick && (winCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else if (ctrl.winClear) winCnt <= '0;
    else if (ctrl.winCount && tick && !expire) winCnt <= winCnt + 1'b1;
  end

  // R9
  link_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkValid |=> $stable(linkHeld));

  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= LAST);
endmodule

// File: rtl/run_mon_ctrl.sv
module run_mon_ctrl
  import run_mon_pkg::*;
#(
  parameter bit ARM_WIRE_ONLY = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wireNow,
  input  logic     linkNow,
  input  logic     expire,
  output winCtrl_t ctrl,
  output logic     runValid,
  output logic     runFault
);
  monState_t state, nxt;
  logic bothOn, noneOn, armHit;

  assign bothOn = wireNow && linkNow;
  assign noneOn = !wireNow && !linkNow;

  generate
    if (ARM_WIRE_ONLY) begin : g_wireLed
      assign armHit = wireNow;
    end else begin : g_either
      assign armHit = wireNow || linkNow;
    end
  endgenerate

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BLOCK:  if (noneOn) nxt = ST_IDLE;
      ST_IDLE:   if (bothOn) nxt = ST_RUN;
                 else if (armHit) nxt = ST_WINDOW;
      ST_WINDOW: if (bothOn) nxt = ST_RUN;
                 else if (noneOn) nxt = ST_IDLE;
                 else if (expire) nxt = ST_FAULT;
      ST_RUN:    if (noneOn) nxt = ST_IDLE;
                 else if (!bothOn) nxt = ST_WINDOW;
      ST_FAULT:  nxt = ST_FAULT;
      default:   nxt = ST_BLOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_BLOCK;
    else state <= nxt;
  end

  assign ctrl.winClear = (state != ST_WINDOW);
  assign ctrl.winCount = (state == ST_WINDOW);
  assign runValid = (state == ST_RUN) && bothOn;
  assign runFault = (state == ST_FAULT);

  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    runFault |=> runFault);

  // R5
  fault_no_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    runFault |-> !runValid);

  // R3
  run_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runValid) |-> $past(wireNow && linkNow));

  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runFault) |-> $past(expire));

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && noneOn) |=> (state == ST_IDLE));

  // R8
  wire_led_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ARM_WIRE_ONLY && state == ST_IDLE && !wireNow) |=> (state != ST_WINDOW));
endmodule

// File: rtl/dual_run_monitor.sv
module dual_run_monitor
  import run_mon_pkg::*;
#(
  parameter int WINDOW_TICKS  = 50,
  parameter bit ARM_WIRE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic wireRun,
  input  logic linkValid,
  input  logic linkRun,
  output logic runValid,
  output logic runFault
);
  winCtrl_t winCtrl;
  logic wireNow, linkNow, expire;

  run_mon_dp #(.WINDOW_TICKS(WINDOW_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wireRun(wireRun),
    .linkValid(linkValid), .linkRun(linkRun), .ctrl(winCtrl),
    .wireNow(wireNow), .linkNow(linkNow), .expire(expire)
  );

  run_mon_ctrl #(.ARM_WIRE_ONLY(ARM_WIRE_ONLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wireNow(wireNow), .linkNow(linkNow),
    .expire(expire), .ctrl(winCtrl), .runValid(runValid), .runFault(runFault)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!runValid && !runFault));
endmodule

// File: tb/dual_run_monitor_tb.sv
module dual_run_monitor_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, wireRun = 1'b0, linkValid = 1'b0, linkRun = 1'b0;
  logic runA, faultA, runB, faultB;
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  dual_run_monitor #(.WINDOW_TICKS(6), .ARM_WIRE_ONLY(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wireRun(wireRun),
    .linkValid(linkValid), .linkRun(linkRun), .runValid(runA), .runFault(faultA));

  dual_run_monitor #(.WINDOW_TICKS(3), .ARM_WIRE_ONLY(1'b1)) u_dutB (
    .clk(clk), .rstN(rstN), .tick(tick), .wireRun(wireRun),
    .linkValid(linkValid), .linkRun(linkRun), .runValid(runB), .runFault(faultB));

  // behavioural model: 0 block, 1 idle, 2 window, 3 run, 4 fault
  int mSt[2], mCnt[2];
  int mWin[2] = '{6, 3};
  bit mWireOnly[2] = '{1'b0, 1'b1};
  bit mHeld;

  function automatic bit linkLvl();
    return linkValid ? linkRun : mHeld;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin mSt[i] = 0; mCnt[i] = 0; end
      mHeld = 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit w, l, both, none, exp;
        w = wireRun; l = linkLvl();
        both = w && l; none = !w && !l;
        exp = (mSt[i] == 2) && tick && (mCnt[i] == mWin[i] - 1);
        case (mSt[i])
          0: if (none) mSt[i] = 1;
          1: if (both) mSt[i] = 3;
             else if (w || (!mWireOnly[i] && l)) begin mSt[i] = 2; mCnt[i] = 0; end
          2: if (both) mSt[i] = 3;
             else if (none) mSt[i] = 1;
             else if (exp) mSt[i] = 4;
             else if (tick) mCnt[i]++;
          3: if (none) mSt[i] = 1;
             else if (!both) begin mSt[i] = 2; mCnt[i] = 0; end
          default: ;
        endcase
      end
      if (linkValid) mHeld = linkRun;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit eRA, eRB;
    eRA = (mSt[0] == 3) && wireRun && linkLvl();
    eRB = (mSt[1] == 3) && wireRun && linkLvl();
    chk(runA == eRA, "R3 runValid A", runA, eRA);
    chk(runB == eRB, "R3 runValid B", runB, eRB);
    chk(faultA == (mSt[0] == 4), "R4 runFault A", faultA, mSt[0] == 4);
    chk(faultB == (mSt[1] == 4), "R4 runFault B", faultB, mSt[1] == 4);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic tickN(input int n);
    repeat (n) begin tick = 1'b1; cyc(1); tick = 1'b0; cyc(1); end
  endtask
  task automatic sendLink(input bit v);
    linkValid = 1'b1; linkRun = v; cyc(1); linkValid = 1'b0;
  endtask
  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    wireRun = 1'b1;
    cyc(3);
    chk(!runA && !faultA, "R1 reset outputs", runA | faultA, 0);
    rstN = 1'b1;
    tickN(10);
    chk(!faultA && !faultB, "R1 blocked after reset", faultA | faultB, 0);
    wireRun = 1'b0; cyc(2);

    // R2 wire opens the window; R3 agreement gives run
    wireRun = 1'b1; cyc(1); tickN(2);
    sendLink(1'b1);
    cyc(1);
    chk(runA && runB, "R3 run after agreement", runA & runB, 1);

    // R10 one route withdraws, R9 held serial value keeps window
    wireRun = 1'b0; cyc(1); tickN(2);
    chk(!runA && !faultA, "R10 window reopened", runA | faultA, 0);
    wireRun = 1'b1; cyc(2);
    chk(runA && runB, "R9 held serial level", runA & runB, 1);

    // R6 cancel
    wireRun = 1'b0; sendLink(1'b0); cyc(2);
    sendLink(1'b1); tickN(4);
    sendLink(1'b0); cyc(2);
    chk(!faultA && !faultB, "R6 cancelled without fault", faultA | faultB, 0);
    sendLink(1'b1); tickN(4); sendLink(1'b0); cyc(1);
    chk(!faultA, "R6 count restarts from zero", faultA, 0);

    // R2 lone serial trips A, R8 B ignores it
    sendLink(1'b1); tickN(8);
    chk(faultA == 1'b1, "R2 lone serial arms and trips", faultA, 1);
    chk(faultB == 1'b0, "R8 wire-led ignores lone serial", faultB, 0);

    // R5 fault latched
    wireRun = 1'b1; cyc(3);
    chk(!runA && faultA, "R5 fault holds run low", runA, 0);
    chk(runB == 1'b1, "R5 other instance runs", runB, 1);
    wireRun = 1'b0; sendLink(1'b0); cyc(2);
    chk(faultA == 1'b1, "R5 fault sticky", faultA, 1);

    // R7 agreement on the expiring tick
    rstN = 1'b0; cyc(2); rstN = 1'b1; cyc(1);
    wireRun = 1'b1; cyc(1);
    tickN(5);
    tick = 1'b1; linkValid = 1'b1; linkRun = 1'b1; cyc(1);
    tick = 1'b0; linkValid = 1'b0; cyc(1);
    chk(runA && !faultA, "R7 agreement wins on last tick", faultA, 0);
    chk(faultB == 1'b1, "R4 short window tripped", faultB, 1);
    cyc(3);
    finish();
  end
endmodule